// File: doc/BRIEF.md
# Program Memory Table Access Unit

This block lets a 16-bit data-side access port read and write a program memory whose words are 24 bits wide. Each access carries a 16-bit effective address. The block places the contents of an 8-bit page register above it to form a 24-bit program address. Bit 0 of that address picks a byte within a word. The top bit picks between the user array and a small configuration array. A "low" access reaches bits 15:0 of the addressed word and a "high" access reaches bits 23:16. Either kind can work on a whole word or on a single byte.

Writes never touch the arrays directly. They update one entry of a 64-entry row latch. A single-cycle commit strobe then copies the whole latch into the row that the most recent write addressed, and returns the latch to all ones. Reads return array contents one cycle after the request, together with a valid flag. With the default parameters, the user array holds 8 rows of 64 words (512 words) and the configuration array holds 16 words.

Top module: `pmem_table_unit`

## Requirements
- R1: The program address is {page_q, acc_ea}. page_q resets to 0x00 and loads page_wdata in the cycle after page_we. An access in the same cycle as page_we uses the old page value.
- R2: Address bit 23 (page_q bit 7) selects the user array (0) or the separate configuration array (1). The two arrays never alias.
- R3: The user array responds only when address bits 22:10 are zero; its word index is bits 9:1. The configuration array responds only when bits 22:5 are zero; its word index is bits 4:1. A read outside these ranges returns 0x0000, and a commit aimed at such a row leaves both arrays unchanged.
- R4: A word-mode low read returns bits 15:0 of the word. A word-mode high read returns bits 23:16 in rd_data[7:0] with zero in rd_data[15:8].
- R5: In byte mode, address bit 0 selects the byte. A low access with bit 0 = 0 or 1 reaches bits 7:0 or bits 15:8. A high access with bit 0 = 0 reaches bits 23:16; with bit 0 = 1 it reads 0x0000 and its write has no effect. Byte reads return the byte in rd_data[7:0] with the upper byte zero, and byte writes take acc_wdata[7:0].
- R6: A table write changes only the row latch. A read of the same location before a commit returns the array's previous contents.
- R7: The latch entry is selected by address bits 6:1. A word-mode high write stores acc_wdata[7:0] into bits 23:16. Every write changes only the bits its lane covers.
- R8: A commit copies all 64 latch entries into the user row given by address bits 22:7 of the most recent table write. If that write was in configuration space and its bits 22:7 were zero, entries 0 to 15 go into the configuration array instead.
- R9: After a commit, every latch entry is 0xFFFFFF. A table write presented in the same cycle as commit is dropped.
- R10: A read (acc_valid high, acc_write low) raises rd_valid for exactly the next cycle with its data. No other cycle has rd_valid high.
- R11: After reset, both arrays and all latch entries hold 0xFFFFFF and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_we | input | 1 | Load the page register |
| page_wdata | input | 8 | New page register value |
| acc_valid | input | 1 | Table access request |
| acc_write | input | 1 | 1 = table write, 0 = table read |
| acc_high | input | 1 | 1 = high access (bits 23:16), 0 = low access (bits 15:0) |
| acc_byte | input | 1 | 1 = byte mode, 0 = word mode |
| acc_ea | input | 16 | Effective address (lower 16 address bits) |
| acc_wdata | input | 16 | Write data |
| commit | input | 1 | Copy the row latch into the array and preset it |
| page_q | output | 8 | Current page register |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |

## Verification
The hardest state to reach from the ports is the content of the row latch, because it can be seen only after a commit moves it into an array. This matters most for the preset after a commit and for a write dropped during a commit. Directed sequences commit twice in a row and commit while a write is presented, then read the row back expecting all ones. Random traffic mixes page changes, writes to every lane, reads and commits over a narrowed address range, so that committed rows are read back often. A bench model of the latch, the row tag and both arrays supplies the expected data.

// File: rtl/tbl_pkg.sv
package tbl_pkg;

  localparam int unsigned WORD_W = 24;
  localparam int unsigned ADDR_W = 24;

  typedef enum logic [2:0] {
    LN_NONE = 3'd0,
    LN_WLO  = 3'd1,
    LN_WHI  = 3'd2,
    LN_B0   = 3'd3,
    LN_B1   = 3'd4,
    LN_B2   = 3'd5
  } lane_e;

  function automatic lane_e lane_decode(input logic high, input logic byte_m, input logic sel);
    lane_e l;
    if (!byte_m)      l = high ? LN_WHI : LN_WLO;
    else if (!high)   l = sel ? LN_B1 : LN_B0;
    else              l = sel ? LN_NONE : LN_B2;
    return l;
  endfunction

  function automatic logic [15:0] lane_extract(input logic [WORD_W-1:0] w, input lane_e l);
    logic [15:0] r;
    case (l)
      LN_WLO:  r = w[15:0];
      LN_WHI:  r = {8'h00, w[23:16]};
      LN_B0:   r = {8'h00, w[7:0]};
      LN_B1:   r = {8'h00, w[15:8]};
      LN_B2:   r = {8'h00, w[23:16]};
      default: r = 16'h0000;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] w, input lane_e l,
                                                   input logic [15:0] d);
    logic [WORD_W-1:0] r;
    r = w;
    case (l)
      LN_WLO:  r[15:0]  = d;
      LN_WHI:  r[23:16] = d[7:0];
      LN_B0:   r[7:0]   = d[7:0];
      LN_B1:   r[15:8]  = d[7:0];
      LN_B2:   r[23:16] = d[7:0];
      default: r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tbl_addr_gen.sv
module tbl_addr_gen
  import tbl_pkg::*;
#(
  parameter int unsigned ROW_IDX_W  = 6,
  parameter int unsigned USER_ROW_W = 3,
  parameter int unsigned CFG_IDX_W  = 4,
  localparam int unsigned USER_IDX_W = USER_ROW_W + ROW_IDX_W,
  localparam int unsigned TAG_W      = ADDR_W - 2 - ROW_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  page_we,
  input  logic [7:0]            page_wdata,
  input  logic                  acc_high,
  input  logic                  acc_byte,
  input  logic [15:0]           acc_ea,
  output logic [7:0]            page_q,
  output logic                  space,
  output logic                  user_hit,
  output logic                  cfg_hit,
  output logic [USER_IDX_W-1:0] user_idx,
  output logic [CFG_IDX_W-1:0]  cfg_idx,
  output logic [ROW_IDX_W-1:0]  latch_idx,
  output logic [TAG_W-1:0]      row_tag,
  output lane_e                 lane
);

  logic [7:0]        page_d;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    page_d = page_q;
    if (page_we) page_d = page_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= 8'h00;
    else if (page_we) page_q <= page_d;
  end

  assign addr      = {page_q, acc_ea};
  assign space     = addr[ADDR_W-1];
  assign user_idx  = addr[USER_IDX_W:1];
  assign cfg_idx   = addr[CFG_IDX_W:1];
  assign latch_idx = addr[ROW_IDX_W:1];
  assign row_tag   = addr[ADDR_W-2:ROW_IDX_W+1];
  assign user_hit  = !space && (addr[ADDR_W-2:USER_IDX_W+1] == '0);
  assign cfg_hit   = space  && (addr[ADDR_W-2:CFG_IDX_W+1] == '0);
  assign lane      = lane_decode(acc_high, acc_byte, acc_ea[0]);

endmodule

// File: rtl/tbl_row_latch.sv
module tbl_row_latch
  import tbl_pkg::*;
#(
  parameter int unsigned ROW_IDX_W = 6,
  localparam int unsigned ROW_WORDS = 1 << ROW_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ROW_IDX_W-1:0] wr_idx,
  input  lane_e                wr_lane,
  input  logic [15:0]          wr_data,
  input  logic                 commit,
  output logic [WORD_W-1:0]    latch_q [ROW_WORDS]
);

  for (genvar gi = 0; gi < ROW_WORDS; gi++) begin : g_entry
    logic              en;
    logic [WORD_W-1:0] d;
    logic [WORD_W-1:0] q;

    always_comb begin
      en = commit || (wr_en && (wr_idx == ROW_IDX_W'(gi)));
      d  = commit ? {WORD_W{1'b1}} : lane_merge(q, wr_lane, wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= {WORD_W{1'b1}};
      else if (en) q <= d;
    end

    assign latch_q[gi] = q;
  end

endmodule

// File: rtl/tbl_prog_array.sv
module tbl_prog_array
  import tbl_pkg::*;
#(
  parameter int unsigned ROW_IDX_W  = 6,
  parameter int unsigned USER_ROW_W = 3,
  parameter int unsigned CFG_IDX_W  = 4,
  localparam int unsigned ROW_WORDS  = 1 << ROW_IDX_W,
  localparam int unsigned USER_IDX_W = USER_ROW_W + ROW_IDX_W,
  localparam int unsigned USER_WORDS = 1 << USER_IDX_W,
  localparam int unsigned CFG_WORDS  = 1 << CFG_IDX_W,
  localparam int unsigned TAG_W      = ADDR_W - 2 - ROW_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic                  wr_space,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic                  commit,
  input  logic [WORD_W-1:0]     latch_q [ROW_WORDS],
  input  logic                  rd_en,
  input  logic                  rd_user_hit,
  input  logic                  rd_cfg_hit,
  input  logic [USER_IDX_W-1:0] rd_user_idx,
  input  logic [CFG_IDX_W-1:0]  rd_cfg_idx,
  output logic [WORD_W-1:0]     rd_word_q
);

  logic                  tag_space_q, tag_space_d;
  logic [TAG_W-1:0]      tag_row_q, tag_row_d;
  logic                  tag_en;
  logic                  commit_user, commit_cfg;
  logic [USER_ROW_W-1:0] commit_row;
  logic [WORD_W-1:0]     user_rd [USER_WORDS];
  logic [WORD_W-1:0]     cfg_rd  [CFG_WORDS];
  logic [WORD_W-1:0]     rd_word_d;

  always_comb begin
    tag_en      = wr_stb && !commit;
    tag_space_d = wr_space;
    tag_row_d   = wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_space_q <= 1'b0;
      tag_row_q   <= '0;
    end else if (tag_en) begin
      tag_space_q <= tag_space_d;
      tag_row_q   <= tag_row_d;
    end
  end

  always_comb begin
    commit_row  = tag_row_q[USER_ROW_W-1:0];
    commit_user = commit && !tag_space_q && (tag_row_q[TAG_W-1:USER_ROW_W] == '0);
    commit_cfg  = commit && tag_space_q && (tag_row_q == '0);
  end

  for (genvar gi = 0; gi < USER_WORDS; gi++) begin : g_user
    localparam int unsigned ROW = gi / ROW_WORDS;
    localparam int unsigned COL = gi % ROW_WORDS;
    logic              en;
    logic [WORD_W-1:0] q;

    assign en = commit_user && (commit_row == USER_ROW_W'(ROW));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= {WORD_W{1'b1}};
      else if (en) q <= latch_q[COL];
    end

    assign user_rd[gi] = q;
  end

  for (genvar gi = 0; gi < CFG_WORDS; gi++) begin : g_cfg
    logic [WORD_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= {WORD_W{1'b1}};
      else if (commit_cfg) q <= latch_q[gi];
    end

    assign cfg_rd[gi] = q;
  end

  always_comb begin
    rd_word_d = '0;
    if (rd_user_hit)     rd_word_d = user_rd[rd_user_idx];
    else if (rd_cfg_hit) rd_word_d = cfg_rd[rd_cfg_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_word_q <= '0;
    else if (rd_en) rd_word_q <= rd_word_d;
  end

endmodule

// File: rtl/pmem_table_unit.sv
module pmem_table_unit
  import tbl_pkg::*;
#(
  parameter int unsigned ROW_IDX_W  = 6,
  parameter int unsigned USER_ROW_W = 3,
  parameter int unsigned CFG_IDX_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        page_we,
  input  logic [7:0]  page_wdata,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic        acc_high,
  input  logic        acc_byte,
  input  logic [15:0] acc_ea,
  input  logic [15:0] acc_wdata,
  input  logic        commit,
  output logic [7:0]  page_q,
  output logic        rd_valid,
  output logic [15:0] rd_data
);

  localparam int unsigned ROW_WORDS  = 1 << ROW_IDX_W;
  localparam int unsigned USER_IDX_W = USER_ROW_W + ROW_IDX_W;
  localparam int unsigned TAG_W      = ADDR_W - 2 - ROW_IDX_W;

  logic [1:0]            rst_sync_q;
  logic                  rst_n_s;
  logic                  space, user_hit, cfg_hit;
  logic [USER_IDX_W-1:0] user_idx;
  logic [CFG_IDX_W-1:0]  cfg_idx;
  logic [ROW_IDX_W-1:0]  latch_idx;
  logic [TAG_W-1:0]      row_tag;
  lane_e                 lane;
  logic                  rd_en, wr_en;
  logic [WORD_W-1:0]     latch_q [ROW_WORDS];
  logic [WORD_W-1:0]     rd_word_q;
  logic                  rd_valid_q, rd_valid_d;
  lane_e                 rd_lane_q, rd_lane_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign rd_en = acc_valid && !acc_write;
  assign wr_en = acc_valid && acc_write;

  tbl_addr_gen #(
    .ROW_IDX_W (ROW_IDX_W),
    .USER_ROW_W(USER_ROW_W),
    .CFG_IDX_W (CFG_IDX_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .page_we   (page_we),
    .page_wdata(page_wdata),
    .acc_high  (acc_high),
    .acc_byte  (acc_byte),
    .acc_ea    (acc_ea),
    .page_q    (page_q),
    .space     (space),
    .user_hit  (user_hit),
    .cfg_hit   (cfg_hit),
    .user_idx  (user_idx),
    .cfg_idx   (cfg_idx),
    .latch_idx (latch_idx),
    .row_tag   (row_tag),
    .lane      (lane)
  );

  tbl_row_latch #(
    .ROW_IDX_W(ROW_IDX_W)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (wr_en),
    .wr_idx (latch_idx),
    .wr_lane(lane),
    .wr_data(acc_wdata),
    .commit (commit),
    .latch_q(latch_q)
  );

  tbl_prog_array #(
    .ROW_IDX_W (ROW_IDX_W),
    .USER_ROW_W(USER_ROW_W),
    .CFG_IDX_W (CFG_IDX_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_stb     (wr_en),
    .wr_space   (space),
    .wr_tag     (row_tag),
    .commit     (commit),
    .latch_q    (latch_q),
    .rd_en      (rd_en),
    .rd_user_hit(user_hit),
    .rd_cfg_hit (cfg_hit),
    .rd_user_idx(user_idx),
    .rd_cfg_idx (cfg_idx),
    .rd_word_q  (rd_word_q)
  );

  always_comb begin
    rd_valid_d = rd_en;
    rd_lane_d  = rd_en ? lane : rd_lane_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_valid_q <= 1'b0;
      rd_lane_q  <= LN_NONE;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_lane_q  <= rd_lane_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = lane_extract(rd_word_q, rd_lane_q);

endmodule

// File: rtl/tbl_table_checker.sv
module tbl_table_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        page_we,
  input logic [7:0]  page_wdata,
  input logic        acc_valid,
  input logic        acc_write,
  input logic        acc_high,
  input logic        acc_byte,
  input logic [15:0] acc_ea,
  input logic [7:0]  page_q,
  input logic        rd_valid,
  input logic [15:0] rd_data
);

  logic rd_req;
  assign rd_req = acc_valid && !acc_write;

  a_r1_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |=> (page_q == $past(page_wdata)));

  a_r1_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !page_we |=> $stable(page_q));

  a_r10_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  a_r4_high_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_high) |=> (rd_data[15:8] == 8'h00));

  a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_byte) |=> (rd_data[15:8] == 8'h00));

  a_r5_high_odd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_high && acc_byte && acc_ea[0]) |=> (rd_data == 16'h0000));

  a_r3_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (page_q[6:0] != 7'd0)) |=> (rd_data == 16'h0000));

endmodule

bind pmem_table_unit tbl_table_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .page_we   (page_we),
  .page_wdata(page_wdata),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_high  (acc_high),
  .acc_byte  (acc_byte),
  .acc_ea    (acc_ea),
  .page_q    (page_q),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data)
);

// File: tb/tb_pmem_table_unit.sv
module tb_pmem_table_unit;

  logic        clk;
  logic        rst_n;
  logic        page_we;
  logic [7:0]  page_wdata;
  logic        acc_valid, acc_write, acc_high, acc_byte;
  logic [15:0] acc_ea, acc_wdata;
  logic        commit;
  logic [7:0]  page_q;
  logic        rd_valid;
  logic [15:0] rd_data;

  int n_checks;
  int n_fail;

  logic [23:0] m_user [512];
  logic [23:0] m_cfg  [16];
  logic [23:0] m_lat  [64];
  logic [7:0]  m_page;
  logic        m_tag_space;
  logic [15:0] m_tag_row;

  pmem_table_unit dut (
    .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_wdata(page_wdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_high(acc_high),
    .acc_byte(acc_byte), .acc_ea(acc_ea), .acc_wdata(acc_wdata),
    .commit(commit), .page_q(page_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // 100 MHz clock: 10 time units per period
  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic h, input logic b, input logic [15:0] ea);
    logic [23:0] a;
    logic [23:0] w;
    a = {m_page, ea};
    if (!a[23] && a[22:10] == 13'd0)     w = m_user[a[9:1]];
    else if (a[23] && a[22:5] == 18'd0)  w = m_cfg[a[4:1]];
    else                                 w = 24'h0;
    if (!b)       return h ? {8'h00, w[23:16]} : w[15:0];
    else if (!h)  return ea[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    else          return ea[0] ? 16'h0000 : {8'h00, w[23:16]};
  endfunction

  task automatic model_write(input logic h, input logic b, input logic [15:0] ea, input logic [15:0] d);
    logic [23:0] w;
    w = m_lat[ea[6:1]];
    if (!b && !h)      w[15:0] = d;
    else if (!b && h)  w[23:16] = d[7:0];
    else if (!h)       begin if (ea[0]) w[15:8] = d[7:0]; else w[7:0] = d[7:0]; end
    else if (!ea[0])   w[23:16] = d[7:0];
    m_lat[ea[6:1]] = w;
    m_tag_space = m_page[7];
    m_tag_row   = {m_page[6:0], ea[15:7]};
  endtask

  task automatic model_commit();
    if (!m_tag_space && m_tag_row[15:3] == 13'd0) begin
      for (int i = 0; i < 64; i++) m_user[m_tag_row[2:0]*64 + i] = m_lat[i];
    end else if (m_tag_space && m_tag_row == 16'd0) begin
      for (int i = 0; i < 16; i++) m_cfg[i] = m_lat[i];
    end
    for (int i = 0; i < 64; i++) m_lat[i] = 24'hFFFFFF;
  endtask

  task automatic idle_inputs();
    page_we = 0; acc_valid = 0; acc_write = 0; acc_high = 0; acc_byte = 0;
    commit = 0;
  endtask

  task automatic set_page(input logic [7:0] p);
    @(negedge clk); page_we = 1; page_wdata = p;
    @(negedge clk); page_we = 0;
    m_page = p;
  endtask

  task automatic tbl_write(input logic h, input logic b, input logic [15:0] ea, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_high = h; acc_byte = b; acc_ea = ea; acc_wdata = d;
    @(negedge clk); idle_inputs();
    model_write(h, b, ea, d);
  endtask

  task automatic tbl_read(input logic h, input logic b, input logic [15:0] ea, input string req);
    logic [15:0] exp;
    exp = model_read(h, b, ea);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_high = h; acc_byte = b; acc_ea = ea;
    @(negedge clk); idle_inputs();
    check(rd_valid === 1'b1 && rd_data === exp, req, {15'd0, rd_valid, rd_data}, {15'd0, 1'b1, exp});
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    model_commit();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] ea_r;
    n_checks = 0; n_fail = 0;
    void'($urandom(32'd24681));
    idle_inputs(); page_wdata = 0; acc_ea = 0; acc_wdata = 0;
    m_page = 0; m_tag_space = 0; m_tag_row = 0;
    for (int i = 0; i < 512; i++) m_user[i] = 24'hFFFFFF;
    for (int i = 0; i < 16; i++)  m_cfg[i]  = 24'hFFFFFF;
    for (int i = 0; i < 64; i++)  m_lat[i]  = 24'hFFFFFF;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11 / R1 reset state
    check(rd_valid === 1'b0, "R11 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    check(page_q === 8'h00, "R1 page after reset", {24'd0, page_q}, 32'd0);
    tbl_read(0, 0, 16'h0000, "R11 erased array reads ones");
    @(negedge clk);
    check(rd_valid === 1'b0, "R10 valid lasts one cycle", {31'd0, rd_valid}, 32'd0);

    // R6 write stays in latch, R8 commit, R4 word lanes
    tbl_write(0, 0, 16'h0010, 16'h1234);
    check(rd_valid === 1'b0, "R10 write gives no valid", {31'd0, rd_valid}, 32'd0);
    tbl_read(0, 0, 16'h0010, "R6 array unchanged before commit");
    do_commit();
    tbl_read(0, 0, 16'h0010, "R8 committed low word");
    tbl_read(1, 0, 16'h0010, "R4 high word upper zero");

    // R5 / R7 byte lanes
    tbl_write(0, 1, 16'h0020, 16'hFFAB);
    tbl_write(0, 1, 16'h0021, 16'h11CD);
    tbl_write(1, 1, 16'h0020, 16'h225A);
    tbl_write(1, 1, 16'h0021, 16'h0077);
    tbl_write(1, 0, 16'h0040, 16'hEE3C);
    do_commit();
    tbl_read(0, 1, 16'h0020, "R5 low byte select 0");
    tbl_read(0, 1, 16'h0021, "R5 low byte select 1");
    tbl_read(1, 1, 16'h0020, "R5 high byte select 0");
    tbl_read(1, 1, 16'h0021, "R5 high byte select 1 reads zero");
    tbl_read(0, 0, 16'h0020, "R7 merged low word");
    tbl_read(1, 0, 16'h0020, "R5 high odd write ignored");
    tbl_read(1, 0, 16'h0040, "R7 high word write lane");
    tbl_read(0, 0, 16'h0040, "R7 low bits untouched");

    // R9 preset after commit
    do_commit();
    tbl_read(0, 0, 16'h0020, "R9 latch preset to ones");

    // R9 write during commit dropped
    tbl_write(0, 0, 16'h0030, 16'h5555);
    @(negedge clk);
    commit = 1; acc_valid = 1; acc_write = 1; acc_high = 0; acc_byte = 0;
    acc_ea = 16'h0032; acc_wdata = 16'hAAAA;
    @(negedge clk); idle_inputs();
    model_commit();
    tbl_read(0, 0, 16'h0030, "R8 commit copies row");
    do_commit();
    tbl_read(0, 0, 16'h0032, "R9 write in commit cycle dropped");

    // R2 configuration space
    set_page(8'h80);
    tbl_write(0, 0, 16'h0004, 16'hBEEF);
    tbl_write(1, 0, 16'h0004, 16'h0042);
    do_commit();
    tbl_read(0, 0, 16'h0004, "R2 config low word");
    tbl_read(1, 0, 16'h0004, "R2 config high word");
    tbl_read(0, 0, 16'h0020, "R3 config out of range");
    set_page(8'h00);
    tbl_read(0, 0, 16'h0004, "R2 user word not aliased");

    // R3 out-of-range user
    tbl_read(0, 0, 16'h0400, "R3 user bit 10 out of range");
    set_page(8'h01);
    tbl_read(0, 0, 16'h0010, "R3 page bits out of range");
    tbl_write(0, 0, 16'h0010, 16'h0BAD);
    do_commit();
    set_page(8'h00);
    tbl_read(0, 0, 16'h0010, "R3 commit out of range ignored");

    // R1 access in same cycle as page write uses old page
    begin
      logic [15:0] exp;
      exp = model_read(0, 0, 16'h0010);
      @(negedge clk);
      page_we = 1; page_wdata = 8'h01;
      acc_valid = 1; acc_write = 0; acc_high = 0; acc_byte = 0; acc_ea = 16'h0010;
      @(negedge clk); idle_inputs();
      m_page = 8'h01;
      check(rd_valid === 1'b1 && rd_data === exp, "R1 old page used", {15'd0, rd_valid, rd_data},
            {15'd0, 1'b1, exp});
      check(page_q === 8'h01, "R1 page loaded", {24'd0, page_q}, 32'h01);
    end
    set_page(8'h00);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int unsigned op;
      op = $urandom % 20;
      ea_r = ($urandom % 4 != 0) ? 16'($urandom & 32'h03FF) : 16'($urandom);
      if (op < 2) begin
        case ($urandom % 8)
          0, 1, 2, 3: set_page(8'h00);
          4, 5:       set_page(8'h80);
          6:          set_page(8'h01);
          default:    set_page(8'($urandom));
        endcase
      end else if (op < 10) begin
        tbl_write(1'($urandom), 1'($urandom), ea_r, 16'($urandom));
      end else if (op < 18) begin
        tbl_read(1'($urandom), 1'($urandom), ea_r, "R7 random read");
      end else begin
        do_commit();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule